// File: doc/BRIEF.md
# Dual Reference Clock Supervisor with Failover

The block supervises two reference clocks against a free-running local clock. It counts fixed windows on the local clock and marks a reference as dead when a whole window passes without one of its rising edges. A dead reference sets a per-input failure flag and raises an interrupt. A reference counts as qualified only after a run of consecutive windows that each hold an edge.

The block forwards one qualified reference to its clock output, resampled into the local domain. When the active reference stops, the output moves to the other qualified reference. The move is made only while the output is held low, and only on a falling edge of the new reference, so no shortened phase reaches the output. When no qualified reference remains, the block enters holdover and holds the output low. It leaves holdover when a reference qualifies again. The PLL and oscillator steering that would act on holdover lie outside the block.

Configuration inputs switch each input's supervision off and select the flag policy. In revertive mode a flag clears by itself when its input qualifies again. In sticky mode a flag stays set until software clears it.

Top module: `refclk_guard`

## Requirements
- R1: An enabled, qualified input whose rising edges stop has its `fail_flag` bit set within 2*WIN_CYC+8 local cycles. A qualified input whose rising edges come less than WIN_CYC local cycles apart is never flagged.
- R2: `irq` is high exactly while at least one `fail_flag` bit is high.
- R3: When the active input stops qualifying and the other input is qualified, `sel_idx` moves to the other input (0 = first reference, 1 = second). Afterwards `ref_out` keeps toggling with the active reference.
- R4: `sel_idx` changes only in a cycle where `ref_out` is low and was also low in the cycle before. When both references have half periods of at least 4 local cycles, every high phase and every low phase of `ref_out` lasts at least 3 local cycles.
- R5: `holdover` is 1 exactly while no input is qualified, and `ref_out` is 0 while `holdover` is 1. An input is qualified when it is enabled and the last REC_WIN windows each held one of its edges. On leaving holdover the block selects a qualified input, preferring index 0.
- R6: While `cfg_off[i]` is 1, `fail_flag[i]` is 0 from the next cycle on. Input i is also never qualified and never becomes the active input.
- R7: With `cfg_revert` = 1, a set `fail_flag[i]` returns to 0 when input i qualifies again.
- R8: With `cfg_revert` = 0, a set `fail_flag[i]` stays 1 until a cycle with `sw_clr[i]` = 1. A one-cycle high pulse on bit i clears bit i.
- R9: After reset, `holdover` = 1, `sel_idx` = 0, `ref_out` = 0, `fail_flag` = 0 and `irq` = 0.
- R10: Selection is non-revertive. When a failed input qualifies again, the active input does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Free-running local clock |
| rst_sys_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_clk | input | 2 | The two reference clocks |
| cfg_off | input | 2 | Per-input supervision off (1 = off, never qualified or flagged) |
| cfg_revert | input | 1 | 1 = flags clear on requalification, 0 = flags stay set until cleared |
| sw_clr | input | 2 | Per-input flag clear strobe |
| ref_out | output | 1 | Selected reference, resampled in the local domain |
| sel_idx | output | 1 | Index of the active reference |
| holdover | output | 1 | 1 while no reference is qualified |
| fail_flag | output | 2 | Per-input failure status |
| irq | output | 1 | Interrupt, high while any failure flag is set |

## Verification
The bench builds the block with its default values: a 16-cycle window and 4 requalification windows. Both references get random half periods between 82 and 140 ns, so every window holds at least one rising edge. With these values, detection, requalification and a full park-and-switch all complete within a 300-cycle settle period. The bench can then step through stopping and restarting each reference, switching supervision off and on, changing the flag policy and clearing flags, and it checks a steady state after each step. The settle loops also measure detection latency and the length of every output phase.

// File: rtl/refclk_guard_pkg.sv
package refclk_guard_pkg;
  localparam int NREF = 2;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_RUN  = 2'd1,
    ST_PARK = 2'd2
  } sel_st_e;
endpackage

// File: rtl/refclk_guard_sync.sv
module refclk_guard_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/refclk_guard_mon.sv
module refclk_guard_mon #(
  parameter int REC_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic win_end,
  input  logic mon_off,
  input  logic revert,
  input  logic clr,
  output logic alive,
  output logic quiet,
  output logic lvl,
  output logic flag
);
  localparam int CW = $clog2(REC_WIN + 1);

  // toggle flop in the reference domain
  logic tog_q;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  logic [1:0] syn;
  refclk_guard_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({tog_q, ref_clk}), .q(syn)
  );

  logic          tog_d_q, seen_q, alive_q, quiet_q, flag_q;
  logic [CW-1:0] good_q;
  logic          seen_n, alive_n, quiet_n, flag_n;
  logic [CW-1:0] good_n;
  logic          edge_hit, had, fall_ev, rise_ev, last_good;

  assign edge_hit  = syn[1] ^ tog_d_q;
  assign had       = seen_q | edge_hit;
  assign last_good = (good_q == CW'(REC_WIN - 1));
  assign fall_ev   = win_end & ~had & alive_q & ~mon_off;
  assign rise_ev   = win_end & had & ~alive_q & ~mon_off & last_good;

  always_comb begin
    seen_n  = win_end ? 1'b0 : had;
    quiet_n = win_end ? ~had : quiet_q;
    alive_n = alive_q;
    good_n  = good_q;
    if (mon_off) begin
      alive_n = 1'b0;
      good_n  = '0;
    end else if (win_end) begin
      if (!had) begin
        alive_n = 1'b0;
        good_n  = '0;
      end else if (!alive_q) begin
        if (last_good) begin
          alive_n = 1'b1;
          good_n  = '0;
        end else begin
          good_n = good_q + CW'(1);
        end
      end
    end

    flag_n = flag_q;
    if (mon_off)               flag_n = 1'b0;
    else if (fall_ev)          flag_n = 1'b1;
    else if (clr)              flag_n = 1'b0;
    else if (revert && rise_ev) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d_q <= 1'b0;
      seen_q  <= 1'b0;
      alive_q <= 1'b0;
      quiet_q <= 1'b1;
      good_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      tog_d_q <= syn[1];
      seen_q  <= seen_n;
      alive_q <= alive_n;
      quiet_q <= quiet_n;
      good_q  <= good_n;
      flag_q  <= flag_n;
    end
  end

  assign alive = alive_q;
  assign quiet = quiet_q;
  assign lvl   = syn[0];
  assign flag  = flag_q;
endmodule

// File: rtl/refclk_guard_sel.sv
module refclk_guard_sel
  import refclk_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] usable,
  input  logic [1:0] lvl,
  input  logic [1:0] quiet,
  output logic       ref_out,
  output logic       sel_idx,
  output logic       holdover
);
  sel_st_e    st_q, st_n;
  logic       sel_q, sel_n, out_q, out_n;
  logic [1:0] lvl_d_q, fall, low;
  logic       oth, pick, any_ok;

  assign fall   = lvl_d_q & ~lvl;
  assign low    = ~lvl | quiet;   // a stalled input counts as low
  assign oth    = ~sel_q;
  assign pick   = ~usable[0];
  assign any_ok = |usable;

  always_comb begin
    st_n  = st_q;
    sel_n = sel_q;
    out_n = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        out_n = lvl[sel_q];
        if (!usable[sel_q] && low[sel_q]) begin
          out_n = 1'b0;
          st_n  = any_ok ? ST_PARK : ST_HOLD;
        end
      end
      ST_PARK: begin
        if (usable[oth]) begin
          if (fall[oth]) begin
            sel_n = oth;
            st_n  = ST_RUN;
          end
        end else if (usable[sel_q]) begin
          if (fall[sel_q]) st_n = ST_RUN;
        end else begin
          st_n = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (any_ok && fall[pick]) begin
          sel_n = pick;
          st_n  = ST_RUN;
        end
      end
      default: st_n = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HOLD;
      sel_q   <= 1'b0;
      out_q   <= 1'b0;
      lvl_d_q <= 2'b00;
    end else begin
      st_q    <= st_n;
      sel_q   <= sel_n;
      out_q   <= out_n;
      lvl_d_q <= lvl;
    end
  end

  assign ref_out  = out_q;
  assign sel_idx  = sel_q;
  assign holdover = (st_q == ST_HOLD);
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
  import refclk_guard_pkg::*;
#(
  parameter int WIN_CYC = 16,
  parameter int REC_WIN = 4
) (
  input  logic       clk_sys,
  input  logic       rst_sys_n,
  input  logic [1:0] ref_clk,
  input  logic [1:0] cfg_off,
  input  logic       cfg_revert,
  input  logic [1:0] sw_clr,
  output logic       ref_out,
  output logic       sel_idx,
  output logic       holdover,
  output logic [1:0] fail_flag,
  output logic       irq
);
  localparam int WW = $clog2(WIN_CYC);

  logic [WW-1:0] win_q, win_n;
  logic          win_end;

  assign win_end = (win_q == WW'(WIN_CYC - 1));
  assign win_n   = win_end ? '0 : win_q + WW'(1);

  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) win_q <= '0;
    else            win_q <= win_n;
  end

  logic [NREF-1:0] alive, quiet, lvl;

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    refclk_guard_mon #(.REC_WIN(REC_WIN)) u_mon (
      .clk(clk_sys), .rst_n(rst_sys_n), .ref_clk(ref_clk[g]),
      .win_end(win_end), .mon_off(cfg_off[g]), .revert(cfg_revert),
      .clr(sw_clr[g]), .alive(alive[g]), .quiet(quiet[g]),
      .lvl(lvl[g]), .flag(fail_flag[g])
    );
  end

  refclk_guard_sel u_sel (
    .clk(clk_sys), .rst_n(rst_sys_n), .usable(alive), .lvl(lvl),
    .quiet(quiet), .ref_out(ref_out), .sel_idx(sel_idx),
    .holdover(holdover)
  );

  assign irq = |fail_flag;
endmodule

// File: rtl/refclk_guard_chk.sv
module refclk_guard_chk (
  input logic       clk_sys,
  input logic       rst_sys_n,
  input logic [1:0] cfg_off,
  input logic       cfg_revert,
  input logic [1:0] sw_clr,
  input logic       ref_out,
  input logic       sel_idx,
  input logic       holdover,
  input logic [1:0] fail_flag
);
  p_hold_low_r5: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    holdover |-> !ref_out);

  p_swap_low_r4: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (sel_idx != $past(sel_idx)) |-> (!ref_out && !$past(ref_out)));

  p_off_clean_r6: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (cfg_off != 2'b00) |=> ((fail_flag & $past(cfg_off)) == 2'b00));

  p_sticky0_r8: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (!cfg_revert && fail_flag[0] && !sw_clr[0] && !cfg_off[0]) |=> fail_flag[0]);

  p_sticky1_r8: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (!cfg_revert && fail_flag[1] && !sw_clr[1] && !cfg_off[1]) |=> fail_flag[1]);
endmodule

bind refclk_guard refclk_guard_chk u_chk (
  .clk_sys(clk_sys), .rst_sys_n(rst_sys_n), .cfg_off(cfg_off),
  .cfg_revert(cfg_revert), .sw_clr(sw_clr), .ref_out(ref_out),
  .sel_idx(sel_idx), .holdover(holdover), .fail_flag(fail_flag)
);

// File: tb/refclk_guard_bench.sv
`timescale 1ns/1ps
module refclk_guard_bench;
  localparam int WIN = 16;
  localparam int REC = 4;

  logic       clk_sys = 1'b0;
  logic       rst_sys_n;
  logic [1:0] ref_clk;
  logic [1:0] cfg_off;
  logic       cfg_revert;
  logic [1:0] sw_clr;
  logic       ref_out, sel_idx, holdover, irq;
  logic [1:0] fail_flag;

  refclk_guard #(.WIN_CYC(WIN), .REC_WIN(REC)) u_refclk_guard (
    .clk_sys(clk_sys), .rst_sys_n(rst_sys_n), .ref_clk(ref_clk),
    .cfg_off(cfg_off), .cfg_revert(cfg_revert), .sw_clr(sw_clr),
    .ref_out(ref_out), .sel_idx(sel_idx), .holdover(holdover),
    .fail_flag(fail_flag), .irq(irq)
  );

  always #10 clk_sys = ~clk_sys;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [1:0] run;
  int half0 = 100, half1 = 100;

  // reference generators: a stopped reference keeps its last level
  initial begin
    ref_clk[0] = 1'b0;
    #1;
    forever begin
      #(half0);
      if (run[0]) ref_clk[0] = ~ref_clk[0];
    end
  end
  initial begin
    ref_clk[1] = 1'b0;
    #1;
    forever begin
      #(half1);
      if (run[1]) ref_clk[1] = ~ref_clk[1];
    end
  end

  // output phase monitor (R4) and activity counter (R3)
  int  runts = 0, rises = 0, runlen = 0;
  bit  last_out = 0, seen_edge = 0;
  always @(negedge clk_sys) begin
    if (rst_sys_n) begin
      if (ref_out !== last_out) begin
        if (seen_edge && runlen < 3) runts++;
        if (ref_out) rises++;
        seen_edge = 1;
        last_out  = ref_out;
        runlen    = 1;
      end else begin
        runlen++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model
  logic [1:0] m_flag, m_alive, m_off;
  logic       m_rev, m_sel, m_hold;

  function automatic logic [1:0] next_flag(input logic [1:0] fl, input logic [1:0] pa,
                                           input logic [1:0] na, input logic [1:0] off,
                                           input logic rev);
    logic [1:0] r = fl;
    for (int i = 0; i < 2; i++) begin
      if (off[i])                   r[i] = 1'b0;
      else if (pa[i] && !na[i])     r[i] = 1'b1;
      else if (!pa[i] && na[i] && rev) r[i] = 1'b0;
    end
    return r;
  endfunction

  // kind 0: toggle run, 1: toggle off, 2: toggle revert, 3: clear strobe mask
  task automatic step(input int kind, input int arg);
    logic [1:0] na, newfail;
    int lat [2];
    int runt0;
    case (kind)
      0: run[arg] = ~run[arg];
      1: begin m_off[arg] = ~m_off[arg]; cfg_off = m_off; end
      2: begin m_rev = ~m_rev; cfg_revert = m_rev; end
      default: begin
        sw_clr = arg[1:0];
        m_flag = m_flag & ~arg[1:0];
        @(negedge clk_sys);
        sw_clr = 2'b00;
      end
    endcase
    na = run & ~m_off;
    newfail = m_alive & ~na & ~m_off;
    m_flag = next_flag(m_flag, m_alive, na, m_off, m_rev);
    if (!m_hold && na[m_sel]) begin
      // keep selection (R10)
    end else if (!m_hold && na[~m_sel]) begin
      m_sel = ~m_sel;
    end else if (na == 2'b00) begin
      m_hold = 1'b1;
    end else begin
      m_hold = 1'b0;
      m_sel  = ~na[0];
    end
    m_alive = na;
    lat[0] = -1; lat[1] = -1;
    runt0 = runts;
    for (int c = 1; c <= 300; c++) begin
      @(negedge clk_sys);
      for (int i = 0; i < 2; i++)
        if (lat[i] < 0 && fail_flag[i]) lat[i] = c;
      if (c == 240) rises = 0;
    end
    for (int i = 0; i < 2; i++)
      if (newfail[i]) chk("R1 detect latency in bound", int'(lat[i] > 0 && lat[i] <= 2*WIN+8), 1);
    chk("R1 fail_flag", int'(fail_flag), int'(m_flag));
    chk("R2 irq", int'(irq), int'(m_flag != 2'b00));
    chk("R5 holdover", int'(holdover), int'(m_hold));
    if (!m_hold) begin
      chk("R3 sel_idx", int'(sel_idx), int'(m_sel));
      chk("R3 ref_out toggles", int'(rises >= 2), 1);
    end else begin
      chk("R5 ref_out quiet in holdover", rises + int'(ref_out), 0);
    end
    chk("R4 no short output phase", runts - runt0, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    half0 = 82 + 2 * int'($urandom % 30);
    half1 = 82 + 2 * int'($urandom % 30);
    run = 2'b00; cfg_off = 2'b00; cfg_revert = 1'b0; sw_clr = 2'b00;
    m_flag = 0; m_alive = 0; m_off = 0; m_rev = 0; m_sel = 0; m_hold = 1;
    rst_sys_n = 1'b0;
    repeat (5) @(negedge clk_sys);
    rst_sys_n = 1'b1;
    @(negedge clk_sys);
    chk("R9 holdover after reset", int'(holdover), 1);
    chk("R9 sel_idx after reset", int'(sel_idx), 0);
    chk("R9 ref_out after reset", int'(ref_out), 0);
    chk("R9 fail_flag after reset", int'(fail_flag), 0);
    chk("R9 irq after reset", int'(irq), 0);

    step(0, 0);                       // start first reference
    step(0, 1);                       // start second
    chk("R10 stays on first", int'(sel_idx), 0);
    step(0, 0);                       // stop first -> switch
    step(0, 0);                       // restart, sticky mode
    chk("R8 flag stays set", int'(fail_flag[0]), 1);
    chk("R10 no switch back", int'(sel_idx), 1);
    step(3, 1);                       // clear strobe
    chk("R8 flag cleared by strobe", int'(fail_flag[0]), 0);
    step(2, 0);                       // revert on
    step(0, 1);                       // stop second
    step(0, 1);                       // restart second
    chk("R7 flag cleared on requalify", int'(fail_flag[1]), 0);
    step(1, 0);                       // supervision off for first
    step(0, 0);                       // stop first while off
    chk("R6 off input not flagged", int'(fail_flag[0]), 0);
    chk("R6 off input not selected", int'(sel_idx), 1);
    step(0, 1);                       // stop second -> holdover
    chk("R5 holdover entered", int'(holdover), 1);
    step(0, 1);                       // restart second
    step(1, 0);
    step(0, 0);

    for (int n = 0; n < 40; n++) begin
      int k, a;
      k = int'($urandom % 4);
      a = (k == 3) ? 1 + int'($urandom % 3) : int'($urandom % 2);
      step(k, a);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_sys);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule